// File: doc/BRIEF.md
# Key Matrix Scanner with Serial Readout Packing

This block scans a keyboard matrix of six scan lines and four return inputs. The six scan lines share their pins with display segment outputs 1 to 6. While the key-scan slot input is high, the block drives exactly one scan line high and samples the four return inputs on that line. At all other times it passes the display segment data through to the same pins. Each line is held for a fixed settle time, and the returns are sampled on the last cycle of that hold. The lines are visited in order from the first to the sixth.

Results collect in a working buffer. They move into the key memory only after the sixth line has been sampled, so a partial scan is never visible. A read command takes a snapshot of the key memory. The snapshot is presented one byte at a time in serial readout order: two scan lines per byte, with the odd line in the low nibble. A separate 4-bit switch port is latched on each end-of-display-cycle pulse and presented as a byte whose upper nibble is zero.

Top module: `kscan_top`

## Requirements
- R1: After an asynchronous reset, the block is scanning from the first line with a zero dwell count. The key memory, the snapshot and the switch latch read as zero.
- R2: While `scan_en_i` is low, `seg_o` equals `seg_data_i`.
- R3: While `scan_en_i` is high, `seg_o` has exactly one bit set. That bit selects the scan line being driven, with bit 0 being the first line.
- R4: Each scan line is driven for SETTLE_CYC enabled cycles (default 2). `key_i` is sampled at the clock edge that ends the last of those cycles. Lines advance from bit 0 to bit 5, and then the scan wraps back to bit 0.
- R5: `key_i` has no effect on any stored result while `scan_en_i` is low.
- R6: A pressed key reads as 1. In key byte b, bits 0 to 3 hold returns 1 to 4 of scan line 2b (0-based). Bits 4 to 7 hold returns 1 to 4 of line 2b+1.
- R7: The key memory is updated only at the edge that samples the last scan line. It then takes all six lines of that scan at once.
- R8: A pulse on `rd_snap_i` copies the key memory (its value before that edge) into the snapshot. `key_byte_o` shows snapshot byte `rd_byte_i` for indices 0 to 2 and reads zero for index 3. It does not change between snapshots.
- R9: `sw_i` is latched only at an edge where `cycle_end_i` is high. `sw_byte_o` carries switch 1 to 4 in bits 0 to 3, and its bits 4 to 7 are always 0.
- R10: While `scan_en_i` is low, the current line and its dwell count hold. Scanning resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scan_en_i | input | 1 | Key-scan slot active |
| seg_data_i | input | 6 | Display data for the shared segment pins |
| key_i | input | 4 | Matrix return inputs, active high |
| sw_i | input | 4 | General-purpose switch inputs |
| cycle_end_i | input | 1 | End-of-display-cycle pulse |
| rd_snap_i | input | 1 | Read command accepted, take a snapshot |
| rd_byte_i | input | 2 | Readout byte index |
| seg_o | output | 6 | Shared segment / scan line pins |
| key_byte_o | output | 8 | Selected key byte of the snapshot |
| sw_byte_o | output | 8 | Latched switch byte |

## Verification
A wrong line pointer or dwell count appears on `seg_o` in the very next enabled cycle. It shows as a line that is skipped, held too long or driven twice. A fault in the working buffer or the commit condition stays hidden until a snapshot is taken. From then on, it appears as a wrong nibble in one specific key byte, and that nibble identifies the line and the returns. The bench therefore runs a cycle-accurate model of the pointer, the buffer, the memory and the snapshot. It compares every output on every clock, so a pointer fault is caught within one cycle, and a storage fault is caught on the first read after the affected scan.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  function automatic int unsigned key_bytes(int unsigned lines);
    return (lines + 1) / 2;
  endfunction

  function automatic int unsigned idx_width(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/kscan_seq.sv
module kscan_seq #(
  parameter int unsigned NUM_LINES  = 6,
  parameter int unsigned SETTLE_CYC = 2,
  localparam int unsigned LINE_W = kscan_pkg::idx_width(NUM_LINES),
  localparam int unsigned CNT_W  = kscan_pkg::idx_width(SETTLE_CYC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scan_en_i,
  output logic [LINE_W-1:0]    line_o,
  output logic [NUM_LINES-1:0] drive_o,
  output logic                 sample_o,
  output logic                 commit_o
);
  logic [LINE_W-1:0] line_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              dwell_done;

  assign dwell_done = (cnt_q == CNT_W'(SETTLE_CYC - 1));
  assign sample_o   = scan_en_i && dwell_done;
  assign commit_o   = sample_o && (line_q == LINE_W'(NUM_LINES - 1));
  assign line_o     = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      cnt_q  <= '0;
    end else if (scan_en_i) begin
      if (dwell_done) begin
        cnt_q  <= '0;
        line_q <= (line_q == LINE_W'(NUM_LINES - 1)) ? '0 : line_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_drive
    assign drive_o[i] = (line_q == LINE_W'(i));
  end
endmodule

// File: rtl/kscan_store.sv
module kscan_store #(
  parameter int unsigned NUM_LINES = 6,
  parameter int unsigned NUM_RET   = 4,
  localparam int unsigned LINE_W    = kscan_pkg::idx_width(NUM_LINES),
  localparam int unsigned BYTE_W    = 2 * NUM_RET,
  localparam int unsigned NUM_BYTES = kscan_pkg::key_bytes(NUM_LINES),
  localparam int unsigned IDX_W     = kscan_pkg::idx_width(NUM_BYTES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_i,
  input  logic               commit_i,
  input  logic [LINE_W-1:0]  line_i,
  input  logic [NUM_RET-1:0] key_i,
  input  logic               rd_snap_i,
  input  logic [IDX_W-1:0]   rd_byte_i,
  output logic [BYTE_W-1:0]  key_byte_o
);
  logic [NUM_LINES-1:0][NUM_RET-1:0] work_q, work_d, mem_q, snap_q;
  logic [BYTE_W-1:0] byte_arr [NUM_BYTES];

  always_comb begin
    work_d = work_q;
    if (sample_i) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (line_i == LINE_W'(i)) work_d[i] = key_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= '0;
      mem_q  <= '0;
      snap_q <= '0;
    end else begin
      work_q <= work_d;
      if (commit_i)  mem_q  <= work_d;
      if (rd_snap_i) snap_q <= mem_q;
    end
  end

  // odd line (0-based even) in the low nibble
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    if (2 * b + 1 < NUM_LINES) begin : g_pair
      assign byte_arr[b] = {snap_q[2*b+1], snap_q[2*b]};
    end else begin : g_single
      assign byte_arr[b] = {{NUM_RET{1'b0}}, snap_q[2*b]};
    end
  end

  always_comb begin
    key_byte_o = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (rd_byte_i == IDX_W'(b)) key_byte_o = byte_arr[b];
    end
  end
endmodule

// File: rtl/kscan_sw.sv
module kscan_sw #(
  parameter int unsigned SW_W   = 4,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cycle_end_i,
  input  logic [SW_W-1:0]   sw_i,
  output logic [BYTE_W-1:0] sw_byte_o
);
  logic [SW_W-1:0] sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sw_q <= '0;
    else if (cycle_end_i) sw_q <= sw_i;
  end

  assign sw_byte_o = BYTE_W'(sw_q);
endmodule

// File: rtl/kscan_top.sv
module kscan_top #(
  parameter int unsigned NUM_LINES  = 6,
  parameter int unsigned NUM_RET    = 4,
  parameter int unsigned SETTLE_CYC = 2,
  parameter int unsigned SW_W       = 4,
  localparam int unsigned BYTE_W    = 2 * NUM_RET,
  localparam int unsigned NUM_BYTES = kscan_pkg::key_bytes(NUM_LINES),
  localparam int unsigned IDX_W     = kscan_pkg::idx_width(NUM_BYTES + 1),
  localparam int unsigned LINE_W    = kscan_pkg::idx_width(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scan_en_i,
  input  logic [NUM_LINES-1:0] seg_data_i,
  input  logic [NUM_RET-1:0]   key_i,
  input  logic [SW_W-1:0]      sw_i,
  input  logic                 cycle_end_i,
  input  logic                 rd_snap_i,
  input  logic [IDX_W-1:0]     rd_byte_i,
  output logic [NUM_LINES-1:0] seg_o,
  output logic [BYTE_W-1:0]    key_byte_o,
  output logic [BYTE_W-1:0]    sw_byte_o
);
  logic [LINE_W-1:0]    line;
  logic [NUM_LINES-1:0] drive;
  logic                 sample, commit;

  kscan_seq #(.NUM_LINES(NUM_LINES), .SETTLE_CYC(SETTLE_CYC)) i_seq (
    .clk_i, .rst_ni, .scan_en_i,
    .line_o(line), .drive_o(drive), .sample_o(sample), .commit_o(commit)
  );

  kscan_store #(.NUM_LINES(NUM_LINES), .NUM_RET(NUM_RET)) i_store (
    .clk_i, .rst_ni,
    .sample_i(sample), .commit_i(commit), .line_i(line), .key_i,
    .rd_snap_i, .rd_byte_i, .key_byte_o
  );

  kscan_sw #(.SW_W(SW_W), .BYTE_W(BYTE_W)) i_sw (
    .clk_i, .rst_ni, .cycle_end_i, .sw_i, .sw_byte_o
  );

  // scan slot owns the shared pins
  assign seg_o = scan_en_i ? drive : seg_data_i;
endmodule

// File: rtl/kscan_chk.sv
module kscan_chk #(
  parameter int unsigned NUM_LINES = 6,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned SW_W      = 4,
  parameter int unsigned NUM_BYTES = 3,
  parameter int unsigned IDX_W     = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 scan_en_i,
  input logic                 cycle_end_i,
  input logic                 rd_snap_i,
  input logic [IDX_W-1:0]     rd_byte_i,
  input logic [NUM_LINES-1:0] seg_o,
  input logic [BYTE_W-1:0]    key_byte_o,
  input logic [BYTE_W-1:0]    sw_byte_o
);
  logic [NUM_LINES-1:0] prev_seg_q, rot_prev;
  logic                 prev_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_seg_q <= '0;
      prev_en_q  <= 1'b0;
    end else begin
      prev_seg_q <= seg_o;
      prev_en_q  <= scan_en_i;
    end
  end

  assign rot_prev = {prev_seg_q[NUM_LINES-2:0], prev_seg_q[NUM_LINES-1]};

  a_r3_one_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |-> $onehot(seg_o));

  a_r4_line_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i && prev_en_q && seg_o != prev_seg_q) |-> seg_o == rot_prev);

  a_r8_snap_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_snap_i |=> (!$stable(rd_byte_i) || $stable(key_byte_o)));

  a_r8_idx_past_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_byte_i >= IDX_W'(NUM_BYTES)) |-> key_byte_o == '0);

  a_r9_sw_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_end_i |=> $stable(sw_byte_o));

  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_byte_o[BYTE_W-1:SW_W] == '0);
endmodule

bind kscan_top kscan_chk #(
  .NUM_LINES(NUM_LINES), .BYTE_W(BYTE_W), .SW_W(SW_W),
  .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)
) i_chk (
  .clk_i, .rst_ni, .scan_en_i, .cycle_end_i, .rd_snap_i, .rd_byte_i,
  .seg_o, .key_byte_o, .sw_byte_o
);

// File: tb/test_kscan_top.sv
`timescale 1ns/1ps
module test_kscan_top;
  logic       clk = 0, rst_n = 0;
  logic       scan_en = 0, cycle_end = 0, rd_snap = 0;
  logic [5:0] seg_data = 6'h2A, seg_o;
  logic [3:0] key_drv, sw = 0, noise = 0;
  logic [1:0] rd_byte = 0;
  logic [7:0] key_byte, sw_byte;
  logic [3:0] pressed [6];
  int checks = 0, failures = 0, cyc = 0;
  bit running = 0, finished = 0;

  // reference model state
  int m_line = 0, m_cnt = 0;
  logic [3:0] m_work [6], m_mem [6], m_snap [6], m_sw;

  always #10 clk = ~clk;

  kscan_top i_kscan_top (
    .clk_i(clk), .rst_ni(rst_n), .scan_en_i(scan_en), .seg_data_i(seg_data),
    .key_i(key_drv), .sw_i(sw), .cycle_end_i(cycle_end), .rd_snap_i(rd_snap),
    .rd_byte_i(rd_byte), .seg_o(seg_o), .key_byte_o(key_byte), .sw_byte_o(sw_byte)
  );

  // matrix: a pressed key connects its driven line to its return
  always_comb begin
    key_drv = '0;
    if (scan_en) begin
      for (int i = 0; i < 6; i++) if (seg_o[i]) key_drv = key_drv | pressed[i];
    end else key_drv = noise;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line = 0; m_cnt = 0; m_sw = 0;
      for (int i = 0; i < 6; i++) begin m_work[i] = 0; m_mem[i] = 0; m_snap[i] = 0; end
    end else begin
      if (rd_snap) for (int i = 0; i < 6; i++) m_snap[i] = m_mem[i];
      if (cycle_end) m_sw = sw;
      if (scan_en) begin
        if (m_cnt == 1) begin
          m_work[m_line] = pressed[m_line];
          if (m_line == 5) for (int i = 0; i < 6; i++) m_mem[i] = m_work[i];
          m_cnt = 0;
          m_line = (m_line + 1) % 6;
        end else m_cnt++;
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_key();
    if (rd_byte == 3) return 8'h00;
    return {m_snap[2*rd_byte+1], m_snap[2*rd_byte]};
  endfunction

  always @(negedge clk) begin
    if (rst_n && running) begin
      if (scan_en) chk("R3 R4 R10 seg_o", {2'b0, seg_o}, {2'b0, 6'(1 << m_line)});
      else         chk("R2 seg_o", {2'b0, seg_o}, {2'b0, seg_data});
      chk("R5 R6 R7 R8 key_byte_o", key_byte, exp_key());
      chk("R9 sw_byte_o", sw_byte, {4'b0, m_sw});
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      noise = 4'($urandom);
    end
  endtask

  task automatic set_pressed(logic [23:0] p);
    for (int i = 0; i < 6; i++) pressed[i] = p[4*i +: 4];
  endtask

  task automatic snap();
    rd_snap = 1; tick(); rd_snap = 0;
  endtask

  task automatic read_all(string tag, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    rd_byte = 0; @(negedge clk); chk(tag, key_byte, b0);
    rd_byte = 1; @(negedge clk); chk(tag, key_byte, b1);
    rd_byte = 2; @(negedge clk); chk(tag, key_byte, b2);
    rd_byte = 3; @(negedge clk); chk("R8 idx3", key_byte, 8'h00);
    tick();
  endtask

  initial begin
    set_pressed('0);
    #35;
    // r1_ reset state
    @(negedge clk);
    chk("R1 seg_o", {2'b0, seg_o}, 8'h2A);
    chk("R1 sw_byte_o", sw_byte, 8'h00);
    rst_n = 1;
    tick();
    read_all("R1 key_byte_o", 8'h00, 8'h00, 8'h00);
    running = 1;

    // idle display, return noise ignored (R2, R5)
    set_pressed(24'hFFFFFF);
    for (int i = 0; i < 8; i++) begin seg_data = 6'(i * 9 + 5); tick(); end
    snap();
    read_all("R5 idle noise", 8'h00, 8'h00, 8'h00);

    // pattern A, one full scan (R4, R6)
    set_pressed({4'b1001, 4'b0100, 4'b1111, 4'b0000, 4'b1010, 4'b0001});
    scan_en = 1; tick(12); scan_en = 0;
    tick(2);
    snap();
    read_all("R6 packing", 8'hA1, 8'hF0, 8'h94);

    // pattern B: half scan invisible (R7), with a pause (R10)
    set_pressed({4'b1000, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 4'b1111});
    scan_en = 1; tick(3); scan_en = 0; tick(5); scan_en = 1; tick(3); scan_en = 0;
    snap();
    read_all("R7 partial scan", 8'hA1, 8'hF0, 8'h94);
    scan_en = 1; tick(6); scan_en = 0;
    read_all("R8 no new snapshot", 8'hA1, 8'hF0, 8'h94);
    snap();
    read_all("R8 new snapshot", 8'h0F, 8'h11, 8'h80);

    // switch latch (R9)
    sw = 4'b1011; tick(3);
    @(negedge clk); chk("R9 no latch", sw_byte, 8'h00);
    cycle_end = 1; tick(); cycle_end = 0; sw = 4'b0110; tick(2);
    @(negedge clk); chk("R9 latched", sw_byte, 8'h0B);
    cycle_end = 1; tick(); cycle_end = 0;
    @(negedge clk); chk("R9 relatched", sw_byte, 8'h06);

    // long mixed run, snapshot coincident with commit
    set_pressed(24'h5A3C96);
    for (int i = 0; i < 200; i++) begin
      scan_en = (i % 7) != 0;
      rd_snap = (i % 13) == 0;
      cycle_end = (i % 11) == 0;
      sw = 4'(i);
      rd_byte = 2'(i);
      seg_data = 6'(i * 5);
      if (i == 100) set_pressed(24'hC30F81);
      tick();
    end
    scan_en = 0; rd_snap = 0; cycle_end = 0;
    tick(2);
    running = 0;
    finished = 1;
    summary();
    $finish;
  end
endmodule